// File: doc/BRIEF.md
# Triple-Channel Majority Voter with Fault Isolation

This block takes three copies of the same data word, one from each of three redundant channels (A, B and C), and produces a single trusted word. While all three channels are in service, every output bit is the majority of the three matching input bits. Comparators watch the channels on every valid sample and raise an error whenever the copies differ.

A channel that stands alone against two agreeing partners is a suspect. It is declared failed only once it has been the odd one out for `CONFIRM` valid samples in a row, so a single glitch does not remove a healthy channel. On that declaration the block leaves majority voting and passes through one surviving channel. It keeps that mode and the identity of the failed channel until a reset. When no two channels agree, the block flags the sample as uncorrectable and keeps its last output word.

All outputs are registered. A sample presented with `in_valid` high at one rising edge appears on the outputs after that edge.

Top module: `tmr_vote_guard`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_err` and `out_uncorr` are 0, `out_word` is 0, `out_mode` is 0 (triple voting) and `out_failed` is 3 (no failed channel).
- R2: In triple mode, a valid sample in which at least two channels agree sets `out_word`, one cycle later, to the bitwise majority of `ch_a`, `ch_b` and `ch_c`.
- R3: One cycle after a valid sample, `out_err` is 1 if the three channels are not all equal, and 0 otherwise. After a cycle without a valid sample, `out_err` is 0.
- R4: A channel is a suspect on a sample when it differs from the other two and those two are equal. A channel is declared failed only when it has been the suspect on `CONFIRM` consecutive valid samples. Any valid sample on which it is not the suspect restarts its count. Samples with `in_valid` low neither add to the count nor restart it.
- R5: In the cycle after the confirming sample, `out_mode` becomes 1 (simplex) and `out_failed` holds the failed channel's index (A=0, B=1, C=2).
- R6: In simplex mode, each valid sample sets `out_word` to the lowest-indexed channel that is not marked failed: B if A failed, otherwise A.
- R7: In triple mode, a valid sample on which no two channels are equal sets `out_uncorr` to 1 for one cycle and leaves `out_word` unchanged. It also restarts every suspect count.
- R8: Once simplex mode is entered, `out_mode` and `out_failed` do not change until reset, whatever the later samples carry.
- R9: `out_valid` repeats `in_valid` one cycle later. A cycle with `in_valid` low leaves `out_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The three channel words carry a sample |
| ch_a | input | WIDTH | Channel A word (index 0) |
| ch_b | input | WIDTH | Channel B word (index 1) |
| ch_c | input | WIDTH | Channel C word (index 2) |
| out_valid | output | 1 | Registered sample strobe |
| out_word | output | WIDTH | Voted or passed-through word |
| out_err | output | 1 | Channels disagreed on the last sample |
| out_uncorr | output | 1 | No two channels agreed on the last sample (triple mode) |
| out_mode | output | 1 | 0 = triple voting, 1 = simplex |
| out_failed | output | 2 | Failed channel index, 3 = none |

## Verification
The bench aims at the edges of the confirmation window. A suspect run that is broken one sample short of `CONFIRM` must not fail the channel, so a design that does not restart its count would drop a healthy channel. Runs with invalid gaps must still confirm, which a design counting or clearing on idle cycles would get wrong. A suspect that alternates between channels, and a three-way split in the middle of a run, must both restart the count. Each failed channel is tried in turn, so a wrong simplex selection or a mode that falls back after later agreement shows up as a wrong word or a changed mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    MODE_TRIPLE  = 1'b0,
    MODE_SIMPLEX = 1'b1
  } tmr_mode_e;

  localparam int NUM_CH = 3;
  localparam logic [1:0] FAILED_NONE = 2'd3;
endpackage

// File: rtl/tmr_majority.sv
module tmr_majority #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_c,
  output logic [WIDTH-1:0] voted
);
  // one three-input voter per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign voted[i] = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
  end
endmodule

// File: rtl/tmr_disagree.sv
module tmr_disagree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_c,
  output logic [2:0]       suspect,
  output logic             any_diff,
  output logic             three_way
);
  logic eq_ab, eq_bc, eq_ac;

  assign eq_ab = (in_a == in_b);
  assign eq_bc = (in_b == in_c);
  assign eq_ac = (in_a == in_c);

  // the odd one out against an agreeing pair
  assign suspect[0] = eq_bc & ~eq_ab;
  assign suspect[1] = eq_ac & ~eq_ab;
  assign suspect[2] = eq_ab & ~eq_bc;

  assign any_diff  = ~(eq_ab & eq_bc);
  assign three_way = ~eq_ab & ~eq_bc & ~eq_ac;
endmodule

// File: rtl/tmr_confirm.sv
module tmr_confirm #(
  parameter int CONFIRM = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [2:0] suspect,
  output logic [2:0] hit
);
  localparam int CNT_W = $clog2(CONFIRM + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONFIRM - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(CONFIRM);

  for (genvar i = 0; i < tmr_pkg::NUM_CH; i++) begin : g_ch
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        run_q <= '0;
      end else if (en) begin
        if (!suspect[i])   run_q <= '0;
        else if (run_q != TOP) run_q <= run_q + 1'b1;
      end
    end

    assign hit[i] = en & suspect[i] & (run_q == LAST);
  end
endmodule

// File: rtl/tmr_vote_guard.sv
module tmr_vote_guard #(
  parameter int WIDTH   = 8,
  parameter int CONFIRM = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] ch_a,
  input  logic [WIDTH-1:0] ch_b,
  input  logic [WIDTH-1:0] ch_c,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_word,
  output logic             out_err,
  output logic             out_uncorr,
  output logic             out_mode,
  output logic [1:0]       out_failed
);
  import tmr_pkg::*;

  tmr_mode_e        mode_q;
  logic [1:0]       failed_q;
  logic [WIDTH-1:0] voted, single_word;
  logic [2:0]       suspect, hit;
  logic             any_diff, three_way, triple_en;

  tmr_majority #(.WIDTH(WIDTH)) u_maj (
    .in_a(ch_a), .in_b(ch_b), .in_c(ch_c), .voted(voted)
  );

  tmr_disagree #(.WIDTH(WIDTH)) u_dd (
    .in_a(ch_a), .in_b(ch_b), .in_c(ch_c),
    .suspect(suspect), .any_diff(any_diff), .three_way(three_way)
  );

  assign triple_en = in_valid & (mode_q == MODE_TRIPLE);

  tmr_confirm #(.CONFIRM(CONFIRM)) u_conf (
    .clk(clk), .rst(rst), .en(triple_en), .suspect(suspect), .hit(hit)
  );

  // the lowest-indexed survivor carries the data in simplex mode
  assign single_word = (failed_q == 2'd0) ? ch_b : ch_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_TRIPLE;
      failed_q   <= FAILED_NONE;
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_err    <= 1'b0;
      out_uncorr <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_err    <= in_valid & any_diff;
      out_uncorr <= triple_en & three_way;
      if (triple_en) begin
        if (!three_way) out_word <= voted;
        if (|hit) begin
          mode_q   <= MODE_SIMPLEX;
          failed_q <= hit[0] ? 2'd0 : (hit[1] ? 2'd1 : 2'd2);
        end
      end else if (in_valid) begin
        out_word <= single_word;
      end
    end
  end

  assign out_mode   = mode_q;
  assign out_failed = failed_q;
endmodule

// File: rtl/tmr_vote_guard_chk.sv
module tmr_vote_guard_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] ch_a,
  input logic [WIDTH-1:0] ch_b,
  input logic [WIDTH-1:0] ch_c,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_word,
  input logic             out_err,
  input logic             out_uncorr,
  input logic             out_mode,
  input logic [1:0]       out_failed
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (out_mode == 1'b0 && out_failed == 2'd3 && !out_valid && !out_err && !out_uncorr));

  assert_pair_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_mode == 1'b0 && ch_a == ch_b) |=> (out_word == $past(ch_a)));

  assert_err_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (ch_a != ch_b || ch_b != ch_c)) |=> out_err);

  assert_no_err_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_valid) |=> !out_err);

  assert_mode_latched_R8: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 1'b1) |=> (out_mode == 1'b1 && $stable(out_failed)));

  assert_failed_named_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_mode) |-> (out_failed != 2'd3));

  assert_simplex_select_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_mode == 1'b1) |=> (out_word == ((out_failed == 2'd0) ? $past(ch_b) : $past(ch_a))));

  assert_uncorr_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_mode == 1'b0 && ch_a != ch_b && ch_b != ch_c && ch_a != ch_c)
      |=> (out_uncorr && $stable(out_word)));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid) |=> (!out_valid && $stable(out_word)));
endmodule

bind tmr_vote_guard tmr_vote_guard_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c),
  .out_valid(out_valid), .out_word(out_word), .out_err(out_err),
  .out_uncorr(out_uncorr), .out_mode(out_mode), .out_failed(out_failed)
);

// File: tb/tmr_vote_guard_bench.sv
module tmr_vote_guard_bench;
  localparam int WIDTH   = 8;
  localparam int CONFIRM = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [WIDTH-1:0] ch_a = '0, ch_b = '0, ch_c = '0;
  logic             out_valid, out_err, out_uncorr, out_mode;
  logic [WIDTH-1:0] out_word;
  logic [1:0]       out_failed;

  always #5 clk = ~clk;

  tmr_vote_guard #(.WIDTH(WIDTH), .CONFIRM(CONFIRM)) u_tmr_vote_guard (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c),
    .out_valid(out_valid), .out_word(out_word), .out_err(out_err),
    .out_uncorr(out_uncorr), .out_mode(out_mode), .out_failed(out_failed)
  );

  int errors = 0;
  int checks = 0;

  // reference state
  int               m_run [3];
  int               m_mode, m_failed, m_valid, m_err, m_uncorr;
  logic [WIDTH-1:0] m_word;
  string            m_word_tag;

  function automatic logic [WIDTH-1:0] majority(logic [WIDTH-1:0] a, b, c);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      int ones = int'(a[i]) + int'(b[i]) + int'(c[i]);
      r[i] = (ones >= 2);
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) m_run[i] = 0;
    m_mode = 0; m_failed = 3; m_valid = 0; m_err = 0; m_uncorr = 0;
    m_word = '0; m_word_tag = "R1";
  endtask

  task automatic model_step(logic v, logic [WIDTH-1:0] a, b, c);
    logic [WIDTH-1:0] w [3];
    int odd;
    int agree;
    w[0] = a; w[1] = b; w[2] = c;
    m_valid = v; m_err = 0; m_uncorr = 0;
    if (!v) begin m_word_tag = "R9"; return; end
    m_err = !(a == b && b == c);
    agree = (a == b) + (b == c) + (a == c);
    odd = -1;
    if (agree == 1) begin
      if (b == c) odd = 0; else if (a == c) odd = 1; else odd = 2;
    end
    if (m_mode == 0) begin
      if (agree == 0) begin
        m_uncorr = 1; m_word_tag = "R7";
      end else begin
        m_word = majority(a, b, c); m_word_tag = "R2";
      end
      for (int i = 0; i < 3; i++) begin
        if (i == odd) begin
          m_run[i]++;
          if (m_run[i] >= CONFIRM && m_mode == 0) begin
            m_mode = 1; m_failed = i;
          end
        end else m_run[i] = 0;
      end
    end else begin
      m_word = (m_failed == 0) ? w[1] : w[0];
      m_word_tag = "R6";
    end
  endtask

  task automatic chk(string tag, int actual, int expected, string what);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, actual, expected, $time);
    end
  endtask

  task automatic compare_all();
    chk("R9", int'(out_valid), m_valid, "out_valid");
    chk(m_word_tag, int'(out_word), int'(m_word), "out_word");
    chk("R3", int'(out_err), m_err, "out_err");
    chk("R7", int'(out_uncorr), m_uncorr, "out_uncorr");
    chk("R5", int'(out_mode), m_mode, "out_mode");
    chk("R4", int'(out_failed), m_failed, "out_failed");
  endtask

  // one sample: drive at negedge, model at posedge, compare at next negedge
  task automatic sample(logic v, logic [WIDTH-1:0] a, b, c);
    in_valid = v; ch_a = a; ch_b = b; ch_c = c;
    @(posedge clk);
    model_step(v, a, b, c);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    compare_all();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();                                   // R1
    chk("R1", int'(out_failed), 3, "reset failed index");

    // R2: agreement and bitwise majority with one odd channel each time
    sample(1, 8'h3C, 8'h3C, 8'h3C);
    sample(1, 8'h55, 8'h55, 8'hAA);
    sample(1, 8'hF0, 8'h0F, 8'h0F);
    sample(1, 8'h81, 8'h7E, 8'h81);
    sample(1, 8'h00, 8'h00, 8'h00);
    // R9: idle cycles hold the word
    sample(0, 8'hFF, 8'h12, 8'h34);
    sample(0, 8'h99, 8'h99, 8'h99);
    // R7: three-way split keeps the previous word
    sample(1, 8'h11, 8'h22, 8'h44);
    sample(1, 8'h0F, 8'hF0, 8'h3C);

    // R4: runs broken one short of CONFIRM do not fail C
    sample(1, 8'h10, 8'h10, 8'h11);
    sample(1, 8'h10, 8'h10, 8'h12);
    sample(1, 8'h10, 8'h10, 8'h10);
    sample(1, 8'h20, 8'h20, 8'h21);
    sample(1, 8'h20, 8'h20, 8'h22);
    sample(1, 8'h20, 8'h21, 8'h20);               // B odd restarts C
    sample(1, 8'h20, 8'h20, 8'h23);
    sample(1, 8'h20, 8'h20, 8'h24);
    sample(1, 8'h01, 8'h02, 8'h03);               // R7 three-way restarts
    sample(1, 8'h20, 8'h20, 8'h25);
    chk("R4", int'(out_mode), 0, "no fail before confirm");

    // R4: invalid gaps neither count nor restart; third valid confirms C
    sample(1, 8'h20, 8'h20, 8'h26);
    sample(0, 8'h20, 8'h20, 8'h20);
    sample(1, 8'h20, 8'h20, 8'h27);
    chk("R5", int'(out_failed), 2, "C failed index");
    chk("R5", int'(out_mode), 1, "simplex after C");
    // R6: C failed, so A is used; R8: later patterns do not change the mode
    sample(1, 8'hA1, 8'hB2, 8'hC3);
    sample(1, 8'h44, 8'h55, 8'h55);
    sample(1, 8'h66, 8'h66, 8'h66);
    sample(0, 8'h77, 8'h77, 8'h77);
    chk("R8", int'(out_failed), 2, "failed index latched");

    // B fails: output passes A
    do_reset();
    for (int i = 0; i < CONFIRM; i++) sample(1, 8'h5A, 8'hA5 + 8'(i), 8'h5A);
    chk("R5", int'(out_failed), 1, "B failed index");
    sample(1, 8'h13, 8'h24, 8'h35);
    sample(1, 8'hEE, 8'hEE, 8'hEE);

    // A fails: output passes B
    do_reset();
    for (int i = 0; i < CONFIRM; i++) sample(1, 8'h00 + 8'(i), 8'hC8, 8'hC8);
    chk("R5", int'(out_failed), 0, "A failed index");
    sample(1, 8'h13, 8'h24, 8'h35);
    chk("R6", int'(out_word), 8'h24, "B passed through");
    sample(1, 8'h24, 8'h24, 8'h35);               // R8: A now agrees, mode stays
    chk("R8", int'(out_mode), 1, "mode latched");
    sample(1, 8'h40, 8'h41, 8'h42);

    do_reset();
    chk("R1", int'(out_mode), 0, "mode back to triple");
    sample(1, 8'h3A, 8'hC5, 8'h3A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule